// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up counter, four bits wide by default, that updates on the rising clock edge. An active-low load input presets the counter from a parallel data word at a clock edge. An active-low clear input forces the count to zero. A compile-time parameter selects whether the clear acts at once, without the clock, or only at a rising edge.

Two active-high enables control counting, and the counter advances only when both are high. Only the chain enable also gates the carry output. The carry output goes high when the chain enable is high and the count is at all ones. To build a wider counter, connect the carry output of one stage to the chain enable of the next stage. All stages share the clock, the clear, the load and the count enable.

Top module: `casc_counter`

## Requirements
- R1: All count bits update together on the rising clock edge. With `ld_n` and `clr_n` high and both enables high, the count increases by exactly one at each edge.
- R2: When `ld_n` is low at a rising edge, counting is suppressed and `q` takes the value of `din` at that edge.
- R3: If `ld_n` goes low and then returns high before the rising edge, that edge counts normally and `din` is not captured.
- R4: With `ASYNC_CLEAR` = 1, driving `clr_n` low forces `q` to zero at once, between clock edges.
- R5: With `ASYNC_CLEAR` = 0, a low `clr_n` has no effect between edges. `q` becomes zero at the first rising edge at which `clr_n` is low.
- R6: `q` holds its value at an edge when `en_count` or `en_chain` is low, provided that `ld_n` and `clr_n` are high.
- R7: `carry_out` is combinational. It is 1 exactly when `en_chain` is 1 and `q` is all ones, and it does not depend on `en_count`.
- R8: When the `carry_out` of one stage drives the `en_chain` of the next stage, and all other inputs are shared, the chained stages behave as one binary counter of the combined width. The first stage holds the low-order bits.
- R9: Clear has priority over load, and load has priority over counting.
- R10: When the counter increments from all ones, it wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous, as set by `ASYNC_CLEAR` |
| ld_n | input | 1 | Active-low synchronous parallel load |
| en_count | input | 1 | Count enable; affects counting only |
| en_chain | input | 1 | Chain enable; affects counting and gates `carry_out` |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry, gated by `en_chain` |

## Verification
The assertions check the following on every edge:
- the load result and the increment-by-one rule;
- holding when an enable is low;
- the carry qualifications;
- the clear effect for the selected mode.

Only the bench scenarios can show the remaining behaviour:
- the immediate zeroing of the asynchronous clear between edges, compared with the synchronous variant, which waits for the edge;
- a load request that is withdrawn before the edge;
- that the two chained stages count as a single 8-bit value through the wrap at 255.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_count,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] TERMINAL = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    if (!ld_n)                      nxt = din;
    else if (en_count && en_chain)  nxt = q + ONE;
    else                            nxt = q;
  end

  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate

  assign carry_out = en_chain & (q == TERMINAL);
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic             en_count,
  input logic             en_chain,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] STEP     = WIDTH'(1);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(din));  // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_count && en_chain) |=> q == $past(q) + STEP);  // R1

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_count && en_chain)) |=> $stable(q));  // R6

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clr_n)
    !en_chain |-> !carry_out);  // R7

  AST_CARRY_TERMINAL: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> q == ALL_ONES);  // R7

  generate
    if (ASYNC_CLEAR) begin : g_async_chk
      AST_ASYNC_ZERO: assert property (@(posedge clk)
        !clr_n |-> q == '0);  // R4
    end else begin : g_sync_chk
      AST_SYNC_ZERO: assert property (@(posedge clk)
        !clr_n |=> q == '0);  // R5
    end
  endgenerate
endmodule

bind casc_counter casc_counter_chk #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_chk (
  .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_count(en_count),
  .en_chain(en_chain), .din(din), .q(q), .carry_out(carry_out)
);

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       ld_n = 1'b1;
  logic       en_count = 1'b0;
  logic       en_chain = 1'b0;
  logic [7:0] din = 8'h00;

  logic [3:0] qa0, qa1, qs0, qs1;
  logic       ca0, ca1, cs0, cs1;
  logic [7:0] ref_a, ref_s;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_count(en_count), .en_chain(en_chain),
    .din(din[3:0]), .q(qa0), .carry_out(ca0));
  casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u1 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_count(en_count), .en_chain(ca0),
    .din(din[7:4]), .q(qa1), .carry_out(ca1));
  casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u2 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_count(en_count), .en_chain(en_chain),
    .din(din[3:0]), .q(qs0), .carry_out(cs0));
  casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u3 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_count(en_count), .en_chain(cs0),
    .din(din[7:4]), .q(qs1), .carry_out(cs1));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] cur);
    if (!clr_n)                    return 8'h00;
    else if (!ld_n)                return din;
    else if (en_count && en_chain) return cur + 8'd1;
    else                           return cur;
  endfunction

  task automatic check_all(input string req);
    chk({req, " async pair"}, {qa1, qa0}, ref_a);
    chk({req, " sync pair"},  {qs1, qs0}, ref_s);
    chk({req, " R7 carry async"}, {7'd0, ca1}, {7'd0, en_chain && ref_a == 8'hFF});
    chk({req, " R7 carry sync"},  {7'd0, cs1}, {7'd0, en_chain && ref_s == 8'hFF});
  endtask

  task automatic step(input logic c, input logic l, input logic ec, input logic eh,
                      input logic [7:0] d, input string req);
    clr_n = c; ld_n = l; en_count = ec; en_chain = eh; din = d;
    @(posedge clk);
    ref_a = model(ref_a);
    ref_s = model(ref_s);
    #1;
    check_all(req);
  endtask

  task automatic t_reset;
    ref_a = 8'h00; ref_s = 8'h00;
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R5 reset");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R4 reset");
  endtask

  task automatic t_count_wrap;
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hF0, "R2 preset");
    for (int i = 0; i < 40; i++)
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 R8 R10 count");
  endtask

  task automatic t_load_priority;
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, "R9 load over count");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R2 load idle");
  endtask

  task automatic t_load_withdrawn;
    clr_n = 1'b1; ld_n = 1'b0; en_count = 1'b1; en_chain = 1'b1; din = 8'h77;
    #0.5;
    ld_n = 1'b1;
    @(posedge clk);
    ref_a = model(ref_a);
    ref_s = model(ref_s);
    #1;
    check_all("R3 withdrawn load");
  endtask

  task automatic t_enables;
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R2 load ff");
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6 R7 count off");
    chk("R7 carry ignores en_count", {7'd0, ca1}, 8'h01);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 R7 chain off");
    chk("R7 carry gated", {7'd0, ca1}, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R10 wrap");
  endtask

  task automatic t_clear_priority;
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, "R2 load");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, "R9 clear over load");
  endtask

  task automatic t_async_clear;
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h96, "R2 load");
    clr_n = 1'b0;
    #0.5;
    chk("R4 async immediate", {qa1, qa0}, 8'h00);
    chk("R5 sync waits", {qs1, qs0}, 8'h96);
    @(posedge clk);
    ref_a = 8'h00; ref_s = 8'h00;
    #1;
    chk("R5 sync at edge", {qs1, qs0}, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 after clear");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_count_wrap();
    t_load_priority();
    t_load_withdrawn();
    t_enables();
    t_clear_priority();
    t_async_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule